// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits in front of the page-load logic of a byte-wide non-volatile memory and watches every incoming byte write (an address and a data byte). It recognises two fixed unlock sequences, one of three writes that arms protection and one of six writes that lifts it. It keeps a persistent protected flag and decides, write by write, whether the byte is forwarded to the page buffer, swallowed as a command byte, or turned into a dummy write cycle that burns the programming time but stores nothing.

Command bytes are always consumed. A completed command only takes effect when the next programming cycle ends, signalled on `cycle_done` after the load window has closed. A command with no data bytes behind it still requests a (dummy) write cycle once its load window times out. Every byte of a sequence must arrive within `GAP_MAX` clock cycles of the previous one; a longer gap drops the partial sequence. A write that breaks a sequence returns the matcher to idle and is then treated as an ordinary write under the current protection state.

Top module: `wp_cmd_seq`

## Requirements
- R1: After a synchronous reset `prot_on`, `pass_valid` and `dummy_req` are all 0.
- R2: With protection off, a write that is not part of a command raises `pass_valid` for one cycle on the clock edge that samples the write, with `pass_addr` and `pass_data` equal to the written address and data.
- R3: The arm sequence is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555; its three bytes produce neither `pass_valid` nor `dummy_req`.
- R4: `prot_on` changes only on the edge where `cycle_done` is 1 while no load window is open; a completed command with no following data raises `dummy_req` once when its window times out.
- R5: With protection on, a write not preceded by the arm sequence raises `dummy_req` for one cycle and no `pass_valid`.
- R6: With protection on, bytes written after a complete arm sequence are forwarded through `pass_valid`, and the window then closes without a `dummy_req`.
- R7: The lift sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555; after it and the following `cycle_done`, `prot_on` is 0.
- R8: A sequence byte arriving up to `GAP_MAX` cycles after the previous one continues the match; one arriving later finds the matcher idle and is handled as an ordinary write.
- R9: A write that does not match the next expected command byte sends the matcher to idle and is handled as an ordinary write; the bytes matched before it are discarded.
- R10: `pass_valid` and `dummy_req` are never 1 in the same cycle.
- R11: Only the low 15 address bits take part in command matching; higher address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One byte write is presented this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| cycle_done | input | 1 | Pulse: the current programming cycle has ended |
| prot_on | output | 1 | Write protection is active |
| pass_valid | output | 1 | Strobe: forward this byte to the page buffer |
| pass_addr | output | ADDR_W | Address of the forwarded byte |
| pass_data | output | 8 | Data of the forwarded byte |
| dummy_req | output | 1 | Strobe: start a write cycle that stores nothing |

## Verification
Plain writes with protection off show the forwarding path, while the same plain writes with protection on must flip to dummy requests, separating the two halves of the decision. Complete arm and lift sequences without data, and an arm prefix followed by data, distinguish command consumption, deferred commit and the data-bearing window. Sequences broken at the second and third byte, sequences spaced exactly at the gap limit and one cycle beyond it, and sequences with high address bits set separate the mismatch, timeout and address-compare rules.

// File: rtl/wps_pkg.sv
// Shared constants and matcher state encoding for the write protection sequencer.
package wps_pkg;
    typedef enum logic [2:0] {
        M_IDLE, // no sequence in progress
        M_S1,   // first lead byte seen
        M_S2,   // lead pair seen
        M_ARM,  // arm command complete, load window open
        M_L3,   // 0x80 seen, lift sequence continuing
        M_L4,   // second lead byte of lift seen
        M_L5,   // second lead pair of lift seen
        M_LIFT  // lift command complete, load window open
    } seq_st_t;

    localparam int          CMP_W      = 15;
    localparam logic [14:0] ADR_ODD    = 15'h5555;
    localparam logic [14:0] ADR_EVEN   = 15'h2AAA;
    localparam logic [7:0]  BYTE_LEAD  = 8'hAA;
    localparam logic [7:0]  BYTE_PAIR  = 8'h55;
    localparam logic [7:0]  BYTE_ARM   = 8'hA0;
    localparam logic [7:0]  BYTE_EXT   = 8'h80;
    localparam logic [7:0]  BYTE_LIFT  = 8'h20;
endpackage

// File: rtl/wps_gap_timer.sv
// Inter-byte gap timer. Counts idle cycles while a sequence or load window is
// open and pulses expire when GAP_MAX cycles pass with no write.
// Assumes GAP_MAX >= 2; a write on the expiring cycle wins over the timeout.
module wps_gap_timer #(
    parameter int GAP_MAX = 15000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic hit,
    output logic expire
);
    localparam int CW = (GAP_MAX > 2) ? $clog2(GAP_MAX) : 1;
    localparam logic [CW-1:0] LAST = CW'(GAP_MAX - 1);

    logic [CW-1:0] cnt;

    // Timeout fires on the last idle cycle of the window.
    always_comb expire = armed && !hit && (cnt == LAST);

    // Idle-cycle counter, cleared by each write and whenever disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (hit || !armed)  cnt <= '0;
        else if (!expire)        cnt <= cnt + 1'b1;
        else                     cnt <= '0;
    end

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/wps_matcher.sv
// Command sequence matcher. Tracks progress through the arm and lift
// sequences, classifies each write as command, forwarded or dummy, and reports
// completed commands. Assumes ADDR_W >= 15; only the low 15 bits are compared.
module wps_matcher
    import wps_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              expire,
    input  logic              prot_now,
    output logic              fwd,
    output logic              burn,
    output logic              arm_pend,
    output logic              pend_val,
    output logic              window_open,
    output logic              idle_burn
);
    seq_st_t    st, nxt;
    logic       seen_data;
    logic       ordinary;
    logic [CMP_W-1:0] lo;
    logic       is_lead, is_pair, is_arm, is_ext, is_lift, in_load;

    // Decode the compared address bits against each command byte.
    always_comb begin
        lo      = wr_addr[CMP_W-1:0];
        is_lead = (lo == ADR_ODD)  && (wr_data == BYTE_LEAD);
        is_pair = (lo == ADR_EVEN) && (wr_data == BYTE_PAIR);
        is_arm  = (lo == ADR_ODD)  && (wr_data == BYTE_ARM);
        is_ext  = (lo == ADR_ODD)  && (wr_data == BYTE_EXT);
        is_lift = (lo == ADR_ODD)  && (wr_data == BYTE_LIFT);
        in_load = (st == M_ARM) || (st == M_LIFT);
        window_open = (st != M_IDLE);
    end

    // Next state and per-write classification.
    always_comb begin
        nxt      = st;
        ordinary = 1'b0;
        fwd      = 1'b0;
        burn     = 1'b0;
        arm_pend = 1'b0;
        pend_val = 1'b0;
        if (wr_valid) begin
            unique case (st)
                M_IDLE: if (is_lead) nxt = M_S1; else ordinary = 1'b1;
                M_S1:   if (is_pair) nxt = M_S2;
                        else begin nxt = M_IDLE; ordinary = 1'b1; end
                M_S2: begin
                    if (is_arm) begin
                        nxt = M_ARM; arm_pend = 1'b1; pend_val = 1'b1;
                    end else if (is_ext) begin
                        nxt = M_L3;
                    end else begin
                        nxt = M_IDLE; ordinary = 1'b1;
                    end
                end
                M_L3:   if (is_lead) nxt = M_L4;
                        else begin nxt = M_IDLE; ordinary = 1'b1; end
                M_L4:   if (is_pair) nxt = M_L5;
                        else begin nxt = M_IDLE; ordinary = 1'b1; end
                M_L5: begin
                    if (is_lift) begin
                        nxt = M_LIFT; arm_pend = 1'b1; pend_val = 1'b0;
                    end else begin
                        nxt = M_IDLE; ordinary = 1'b1;
                    end
                end
                M_ARM, M_LIFT: fwd = 1'b1;
                default: nxt = M_IDLE;
            endcase
            if (ordinary) begin
                if (prot_now) burn = 1'b1;
                else          fwd  = 1'b1;
            end
        end else if (expire) begin
            nxt = M_IDLE;
        end
        idle_burn = !wr_valid && expire && in_load && !seen_data;
    end

    // Matcher state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= M_IDLE;
        else        st <= nxt;
    end

    // Remembers whether the current load window carried any data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                  seen_data <= 1'b0;
        else if (arm_pend)           seen_data <= 1'b0;
        else if (wr_valid && in_load) seen_data <= 1'b1;
    end

    assert_gap_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (st == M_IDLE));
    assert_cmd_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_pend |-> (!fwd && !burn));
endmodule

// File: rtl/wps_prot_state.sv
// Persistent protection flag. Holds a pending command until the next
// programming cycle ends with no load window open, then applies it.
module wps_prot_state (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_pend,
    input  logic pend_val,
    input  logic cycle_done,
    input  logic window_open,
    output logic prot_on
);
    logic pend_v, pend_to;
    logic commit;

    // Commit only once the load window of the command has closed.
    always_comb commit = cycle_done && pend_v && !window_open;

    // Pending command register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v  <= 1'b0;
            pend_to <= 1'b0;
        end else if (arm_pend) begin
            pend_v  <= 1'b1;
            pend_to <= pend_val;
        end else if (commit) begin
            pend_v  <= 1'b0;
        end
    end

    // Protection flag, updated at the end of a write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      prot_on <= 1'b0;
        else if (commit) prot_on <= pend_to;
    end

    assert_commit_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on != $past(prot_on)) |-> $past(cycle_done));
endmodule

// File: rtl/wp_cmd_seq.sv
// Write protection command sequencer top. Combines the matcher, gap timer and
// protection flag, and registers the per-write outcome: forward or dummy cycle.
// Assumes at most one byte write per cycle and ADDR_W >= 15.
module wp_cmd_seq #(
    parameter int ADDR_W  = 19,
    parameter int GAP_MAX = 15000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              cycle_done,
    output logic              prot_on,
    output logic              pass_valid,
    output logic [ADDR_W-1:0] pass_addr,
    output logic [7:0]        pass_data,
    output logic              dummy_req
);
    logic fwd, burn, arm_pend, pend_val, window_open, idle_burn, expire;

    wps_gap_timer #(.GAP_MAX(GAP_MAX)) u_gap (
        .clk(clk), .rst_n(rst_n), .armed(window_open), .hit(wr_valid),
        .expire(expire)
    );

    wps_matcher #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .expire(expire), .prot_now(prot_on),
        .fwd(fwd), .burn(burn), .arm_pend(arm_pend), .pend_val(pend_val),
        .window_open(window_open), .idle_burn(idle_burn)
    );

    wps_prot_state u_prot (
        .clk(clk), .rst_n(rst_n), .arm_pend(arm_pend), .pend_val(pend_val),
        .cycle_done(cycle_done), .window_open(window_open), .prot_on(prot_on)
    );

    // Output register for the forwarded byte and dummy-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_valid <= 1'b0;
            pass_addr  <= '0;
            pass_data  <= '0;
            dummy_req  <= 1'b0;
        end else begin
            pass_valid <= fwd;
            dummy_req  <= burn || idle_burn;
            if (fwd) begin
                pass_addr <= wr_addr;
                pass_data <= wr_data;
            end
        end
    end

    assert_pass_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> $past(wr_valid));
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_valid && dummy_req));
    assert_protected_no_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burn) |=> (dummy_req && !pass_valid));
endmodule

// File: tb/sim_wp_cmd_seq.sv
// Scoreboard bench: the driver queues the expected outcome of each write, the
// monitor pops and compares whenever the design emits a strobe.
module sim_wp_cmd_seq;
    localparam int AW = 19;
    localparam int G  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          cycle_done = 1'b0;
    logic          prot_on, pass_valid, dummy_req;
    logic [AW-1:0] pass_addr;
    logic [7:0]    pass_data;

    int checks = 0;
    int errors = 0;

    int            qk[$];
    logic [AW-1:0] qa[$];
    logic [7:0]    qd[$];
    string         qt[$];

    always #5 clk = ~clk;

    wp_cmd_seq #(.ADDR_W(AW), .GAP_MAX(G)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .cycle_done(cycle_done), .prot_on(prot_on),
        .pass_valid(pass_valid), .pass_addr(pass_addr), .pass_data(pass_data),
        .dummy_req(dummy_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Queue an expected outcome: kind 0 = forwarded byte, 1 = dummy cycle.
    task automatic expect_item(input int k, input logic [AW-1:0] a,
                               input logic [7:0] d, input string tag);
        qk.push_back(k); qa.push_back(a); qd.push_back(d); qt.push_back(tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic done_pulse();
        @(negedge clk); cycle_done = 1'b1;
        @(negedge clk); cycle_done = 1'b0;
    endtask

    task automatic arm_seq(input logic [AW-1:0] hi);
        wr(hi | 19'h05555, 8'hAA);
        wr(hi | 19'h02AAA, 8'h55);
        wr(hi | 19'h05555, 8'hA0);
    endtask

    // Monitor: every strobe must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && (pass_valid || dummy_req)) begin
            chk(!(pass_valid && dummy_req), "R10 both strobes", {pass_valid, dummy_req}, 0);
            if (qk.size() == 0) begin
                chk(1'b0, "unexpected strobe", {pass_valid, dummy_req}, 0);
            end else begin
                int k; logic [AW-1:0] a; logic [7:0] d; string t;
                k = qk.pop_front(); a = qa.pop_front(); d = qd.pop_front(); t = qt.pop_front();
                if (k == 0)
                    chk(pass_valid && pass_addr == a && pass_data == d, t,
                        {pass_valid, pass_addr, pass_data}, {1'b1, a, d});
                else
                    chk(dummy_req && !pass_valid, t, {pass_valid, dummy_req}, 1);
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prot_on == 0 && pass_valid == 0 && dummy_req == 0, "R1 reset state",
            {prot_on, pass_valid, dummy_req}, 0);

        // R2: plain writes pass unchanged
        expect_item(0, 19'h01234, 8'h5A, "R2 plain write");
        wr(19'h01234, 8'h5A);
        expect_item(0, 19'h7FFFF, 8'hC3, "R2 top address");
        wr(19'h7FFFF, 8'hC3);

        // R9: broken at byte 2 and at byte 3
        wr(19'h05555, 8'hAA);
        expect_item(0, 19'h00100, 8'h3C, "R9 mismatch at byte 2");
        wr(19'h00100, 8'h3C);
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        expect_item(0, 19'h05555, 8'h77, "R9 mismatch at byte 3");
        wr(19'h05555, 8'h77);

        // R8: gap one cycle beyond the limit aborts the match
        wr(19'h05555, 8'hAA);
        idle(G - 1);
        expect_item(0, 19'h02AAA, 8'h55, "R8 late byte ordinary");
        wr(19'h02AAA, 8'h55);
        idle(2);

        // R3 R4 R11: arm with high bits set, no data
        expect_item(1, '0, '0, "R4 dummy after empty arm");
        arm_seq(19'h40000);
        idle(G + 3);
        chk(prot_on == 0, "R4 no change before cycle end", prot_on, 0);
        chk(qk.size() == 0, "R3 command bytes consumed", qk.size(), 0);
        done_pulse();
        chk(prot_on == 1, "R11 R4 armed after cycle end", prot_on, 1);

        // R5: plain write while protected
        expect_item(1, '0, '0, "R5 protected plain write");
        wr(19'h00200, 8'h11);
        idle(2);
        chk(prot_on == 1, "R5 still protected", prot_on, 1);

        // R6: prefixed data passes while protected
        arm_seq('0);
        expect_item(0, 19'h00300, 8'h01, "R6 data 1");
        wr(19'h00300, 8'h01);
        expect_item(0, 19'h00301, 8'h02, "R6 data 2");
        wr(19'h00301, 8'h02);
        expect_item(0, 19'h05555, 8'hAA, "R6 data 3");
        wr(19'h05555, 8'hAA);
        idle(G + 3);
        chk(qk.size() == 0, "R6 no dummy after data window", qk.size(), 0);
        done_pulse();
        chk(prot_on == 1, "R6 remains protected", prot_on, 1);

        // R7: lift sequence
        expect_item(1, '0, '0, "R7 dummy after empty lift");
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h20);
        idle(G + 3);
        chk(prot_on == 1, "R7 held until cycle end", prot_on, 1);
        done_pulse();
        chk(prot_on == 0, "R7 lifted", prot_on, 0);

        // R8: bytes spaced exactly at the limit still match
        expect_item(1, '0, '0, "R8 spaced arm completes");
        wr(19'h05555, 8'hAA); idle(G - 2);
        wr(19'h02AAA, 8'h55); idle(G - 2);
        wr(19'h05555, 8'hA0);
        idle(G + 3);
        done_pulse();
        chk(prot_on == 1, "R8 spaced arm applied", prot_on, 1);

        idle(4);
        chk(qk.size() == 0, "all expectations met", qk.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule